// File: doc/BRIEF.md
# Carry Increment Adder

A combinational binary adder that splits two operands into 4-bit groups. The lowest group adds the operands together with the external carry-in. Each higher group first adds its operand slices with no carry. It then passes that provisional result through a chain of half adders, which adds the carry arriving from the group below. The carry leaving a higher group is the OR of its own adder's carry and the carry out of its increment chain.

A parameter selects the inner group adder. It can be a chain of full adders or a 4-bit carry-lookahead network. The two forms give identical results, so they can be exchanged when comparing implementations. The width must be a multiple of the group size. Wider operands repeat the increment scheme group after group. Tie the carry-in to zero when it is not needed.

Top module: `cia_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i` for every input combination.
- R2: `carry_o` equals bit WIDTH of `a_i + b_i + cin_i`.
- R3: Only the lowest group uses `cin_i`. Each higher group adds with a zero carry and is then incremented by the carry out of the group below (e.g. 8'h0F + 8'h00 + 1 = 8'h10, no carry).
- R4: In every higher group, the adder's carry and the increment chain's carry are never 1 together. The group's carry-out is their OR.
- R5: All-ones plus zero with `cin_i` = 1 gives `sum_o` = 0 and `carry_o` = 1.
- R6: A carry from the lowest group that enters all-ones upper groups clears them and sets `carry_o` (e.g. 8'hF8 + 8'h08 = 9'h100).
- R7: Zero plus zero with `cin_i` = 0 gives `sum_o` = 0 and `carry_o` = 0.
- R8: `GRP_KIND` = 0 selects the full-adder chain and `GRP_KIND` = 1 selects the lookahead group adder. Both give identical `sum_o` and `carry_o`.
- R9: Any WIDTH that is a multiple of GRP_W = 4 (e.g. 16) meets R1 and R2.
- R10: The block holds no state. Outputs follow a change of inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into the lowest group |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the highest group |

## Verification
Two carry sources meet at each higher group: the group adder's own carry and the carry that ripples out of the increment chain. Only one of them may fire, so the OR that merges them never hides a double count.

The bench provokes both sources. Operand pairs whose upper slices overflow by themselves make the group adder's carry fire. All-ones upper slices fed by a carry from below make the increment carry fire. Each case is judged at the ports against the sum computed in the bench. A check inside each group also flags any cycle in which both carries are high.

// File: rtl/cia_pkg.sv
package cia_pkg;
  localparam int unsigned GRP_W_DEF = 4;
  typedef enum logic [0:0] {
    GRP_RIPPLE    = 1'b0,
    GRP_LOOKAHEAD = 1'b1
  } grp_kind_e;
endpackage

// File: rtl/cia_half_add.sv
module cia_half_add (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i;
  assign c_o = x_i & y_i;
endmodule

// File: rtl/cia_inc_chain.sv
module cia_inc_chain #(
  parameter int unsigned GRP_W = 4
) (
  input  logic [GRP_W-1:0] val_i,
  input  logic             inc_i,
  output logic [GRP_W-1:0] sum_o,
  output logic             cout_o
);
  logic [GRP_W:0] c;
  assign c[0] = inc_i;

  for (genvar i = 0; i < GRP_W; i++) begin : g_ha
    cia_half_add ha_i (
      .x_i (val_i[i]),
      .y_i (c[i]),
      .s_o (sum_o[i]),
      .c_o (c[i+1])
    );
  end
  assign cout_o = c[GRP_W];

  always_comb begin
    if (!$isunknown({val_i, inc_i, cout_o}))
      AST_INC_WRAP: assert (!cout_o || (inc_i && (&val_i))) else $error("inc wrap"); // R3
  end
endmodule

// File: rtl/cia_grp_adder.sv
module cia_grp_adder #(
  parameter int unsigned         GRP_W    = 4,
  parameter cia_pkg::grp_kind_e  GRP_KIND = cia_pkg::GRP_RIPPLE
) (
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             cin_i,
  output logic [GRP_W-1:0] sum_o,
  output logic             cout_o
);
  logic [GRP_W-1:0] p, g;
  assign p = a_i ^ b_i;
  assign g = a_i & b_i;

  if (GRP_KIND == cia_pkg::GRP_RIPPLE) begin : g_rca
    logic [GRP_W:0] rc;
    assign rc[0] = cin_i;
    for (genvar i = 0; i < GRP_W; i++) begin : g_fa
      assign sum_o[i] = p[i] ^ rc[i];
      assign rc[i+1]  = g[i] | (p[i] & rc[i]);
    end
    assign cout_o = rc[GRP_W];
  end else begin : g_cla
    logic [GRP_W:0] lc;
    // each carry from g/p terms and cin directly, no chained dependency
    always_comb begin
      logic term;
      lc[0] = cin_i;
      for (int i = 0; i < GRP_W; i++) begin
        lc[i+1] = g[i];
        for (int j = 0; j < i; j++) begin
          term = g[j];
          for (int k = j + 1; k <= i; k++) term = term & p[k];
          lc[i+1] = lc[i+1] | term;
        end
        term = cin_i;
        for (int k = 0; k <= i; k++) term = term & p[k];
        lc[i+1] = lc[i+1] | term;
      end
    end
    assign sum_o  = p ^ lc[GRP_W-1:0];
    assign cout_o = lc[GRP_W];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i}))
      AST_GRP_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{GRP_W{1'b0}}, cin_i}))
        else $error("group sum"); // R8
  end
endmodule

// File: rtl/cia_adder.sv
module cia_adder #(
  parameter int unsigned        WIDTH    = 8,
  parameter int unsigned        GRP_W    = cia_pkg::GRP_W_DEF,
  parameter cia_pkg::grp_kind_e GRP_KIND = cia_pkg::GRP_RIPPLE
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned N_GRP = WIDTH / GRP_W;

  // grp_c[k] is the carry entering group k
  logic [N_GRP:0] grp_c;
  assign grp_c[0] = cin_i;

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    localparam int unsigned LO = k * GRP_W;
    if (k == 0) begin : g_base
      cia_grp_adder #(.GRP_W(GRP_W), .GRP_KIND(GRP_KIND)) add_i (
        .a_i    (a_i[LO +: GRP_W]),
        .b_i    (b_i[LO +: GRP_W]),
        .cin_i  (grp_c[0]),
        .sum_o  (sum_o[LO +: GRP_W]),
        .cout_o (grp_c[1])
      );
    end else begin : g_upper
      logic [GRP_W-1:0] prov;
      logic             add_c, inc_c;
      cia_grp_adder #(.GRP_W(GRP_W), .GRP_KIND(GRP_KIND)) add_i (
        .a_i    (a_i[LO +: GRP_W]),
        .b_i    (b_i[LO +: GRP_W]),
        .cin_i  (1'b0),
        .sum_o  (prov),
        .cout_o (add_c)
      );
      cia_inc_chain #(.GRP_W(GRP_W)) inc_i (
        .val_i  (prov),
        .inc_i  (grp_c[k]),
        .sum_o  (sum_o[LO +: GRP_W]),
        .cout_o (inc_c)
      );
      assign grp_c[k+1] = add_c | inc_c;

      always_comb begin
        if (!$isunknown({add_c, inc_c}))
          AST_CARRY_EXCL: assert (!(add_c && inc_c)) else $error("carry overlap"); // R4
      end
    end
  end

  assign carry_o = grp_c[N_GRP];

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      AST_SUM_OK: assert (sum_o == WIDTH'({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
        else $error("sum"); // R1
      AST_CARRY_OK: assert (carry_o == (({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}) >> WIDTH))
        else $error("carry"); // R2
    end
  end
endmodule

// File: tb/cia_adder_tb_top.sv
module cia_adder_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  a8, b8, s8, s8la;
  logic        c8, co8, co8la;
  logic [15:0] aw, bw, sw;
  logic        cw, cow;

  cia_adder #(.WIDTH(8), .GRP_KIND(cia_pkg::GRP_RIPPLE)) dut_i (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .carry_o(co8));
  cia_adder #(.WIDTH(8), .GRP_KIND(cia_pkg::GRP_LOOKAHEAD)) dut_la_i (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8la), .carry_o(co8la));
  cia_adder #(.WIDTH(16), .GRP_KIND(cia_pkg::GRP_LOOKAHEAD)) dut_w_i (
    .a_i(aw), .b_i(bw), .cin_i(cw), .sum_o(sw), .carry_o(cow));

  // {a, b, cin, expected sum, expected carry}
  localparam logic [25:0] VEC [10] = '{
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
    {8'hFF, 8'h00, 1'b1, 8'h00, 1'b1},
    {8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
    {8'h0F, 8'h00, 1'b1, 8'h10, 1'b0},
    {8'hF8, 8'h08, 1'b0, 8'h00, 1'b1},
    {8'h0F, 8'hF0, 1'b1, 8'h00, 1'b1},
    {8'h80, 8'h80, 1'b0, 8'h00, 1'b1},
    {8'h7F, 8'h01, 1'b0, 8'h80, 1'b0},
    {8'h12, 8'h34, 1'b1, 8'h47, 1'b0},
    {8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive8(input logic [7:0] a, input logic [7:0] b, input logic c);
    a8 = a; b8 = b; c8 = c;
    #1;
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b, input logic c);
    aw = a; bw = b; cw = c;
    #1;
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a8 = '0; b8 = '0; c8 = 1'b0;
    aw = '0; bw = '0; cw = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 reset zero sum", {55'd0, co8, s8}, 64'd0);
    rst_ni = 1'b1;

    // table walk
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      drive8(VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
      check("R1 R2 table", {55'd0, co8, s8}, {55'd0, VEC[i][0], VEC[i][8:1]});
    end

    // directed corners
    drive8(8'h00, 8'h00, 1'b0);
    check("R7 zero plus zero", {55'd0, co8, s8}, 64'd0);
    drive8(8'hFF, 8'h00, 1'b1);
    check("R5 all ones plus cin", {55'd0, co8, s8}, 64'h100);
    drive8(8'hF8, 8'h08, 1'b0);
    check("R6 low carry through ones", {55'd0, co8, s8}, 64'h100);
    drive8(8'h0F, 8'h00, 1'b1);
    check("R3 cin into lowest group", {55'd0, co8, s8}, 64'h010);
    drive8(8'hF0, 8'hF0, 1'b0);
    check("R4 upper adder carry alone", {55'd0, co8, s8}, 64'h1E0);
    drive8(8'hF1, 8'h0F, 1'b0);
    check("R4 increment carry alone", {55'd0, co8, s8}, 64'h100);
    drive8(8'h10, 8'h01, 1'b0);
    check("R10 follows inputs", {55'd0, co8, s8}, 64'h011);
    a8 = 8'h20;
    #1;
    check("R10 no clock needed", {55'd0, co8, s8}, 64'h021);

    // exhaustive 8-bit, both group adder kinds
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [8:0] exp9;
          drive8(8'(a), 8'(b), 1'(c));
          exp9 = 9'(a) + 9'(b) + 9'(c);
          check("R1 R2 exhaustive ripple", {55'd0, co8, s8}, {55'd0, exp9});
          check("R8 exhaustive lookahead", {55'd0, co8la, s8la}, {55'd0, exp9});
        end
      end
    end

    // 16-bit
    drive16(16'hFFFF, 16'h0000, 1'b1);
    check("R9 R5 16-bit all ones", {47'd0, cow, sw}, 64'h10000);
    drive16(16'h0FFF, 16'h0001, 1'b0);
    check("R9 R6 16-bit chained ones", {47'd0, cow, sw}, 64'h01000);
    drive16(16'hFFF0, 16'h0010, 1'b0);
    check("R9 R6 16-bit top groups", {47'd0, cow, sw}, 64'h10000);
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ra, rb;
      logic        rc;
      logic [16:0] exp17;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rc = 1'($urandom);
      drive16(ra, rb, rc);
      exp17 = {1'b0, ra} + {1'b0, rb} + 17'(rc);
      check("R9 16-bit random", {47'd0, cow, sw}, {47'd0, exp17});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule